// File: doc/BRIEF.md
# Fractional PLL Feedback Tuning Sequencer

This block drives a memory-mapped bus as a master to retune one PLL inside a four-lane transceiver group. A request names a lane (0 to 3), one of three PLLs in that lane, and a new 22-bit fractional feedback value. The value is an unsigned fraction with 22 fractional bits that adds to the PLL's integer multiplier. The block finds the tuning register of the chosen PLL and rewrites only the fractional field in it. It then commits the value by pulsing a strobe bit in a companion register low, high and low again. The new fraction takes effect only after this pulse.

Each of the four register writes is a full read-modify-write, so bits outside the field or the strobe keep the values that were read. The block rejects a request before it touches the bus in two cases: the PLL code is invalid, or the value lies outside a parameterised window. The window is meant to bound rate-matching adjustments to roughly ±1000 ppm.

Top module: `fpll_ktune_seq`

## Requirements
- R1: Tuning register address = 0x094000 + lane × 0x100000 + pll × 0x100, with pll codes slow = 0, medium = 1, fast = 2. The strobe register address is the tuning register address + 0x0C.
- R2: The tuning register write carries the new value in bits [30:9]. Bit 31 and bits [8:0] equal the word read from the same address.
- R3: An accepted request makes exactly four reads and four writes, in this order: the tuning register, then the strobe register three times. The three strobe writes carry bit 17 = 0, 1, 0, and every other strobe bit equals the word just read.
- R4: While waitrequest is high, bus_addr, bus_read, bus_write and bus_wdata hold their values. Read data is taken only in a cycle where readdatavalid is high.
- R5: If the value is below K_MIN or above K_MAX, the next cycle shows done = 1 and err = 1 for one cycle, and no bus access occurs.
- R6: A pll code of 3 produces the same one-cycle done and err response with no bus access.
- R7: busy rises in the cycle after a request is accepted. It stays high until the write that returns bit 17 to 0 has completed. Requests seen while busy is high are ignored.
- R8: A successful update ends with done high for exactly one cycle, err low, and busy low in that same cycle.
- R9: A synchronous reset, even in the middle of an update, returns the block to idle: busy, done, bus_read and bus_write are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_lane | input | 2 | Lane index 0..3 |
| req_pll | input | 2 | PLL code: 0 slow, 1 medium, 2 fast |
| req_kval | input | 22 | New fractional feedback value |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Qualifies done: request rejected |
| bus_addr | output | 24 | Bus address |
| bus_read | output | 1 | Bus read request |
| bus_write | output | 1 | Bus write request |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| bus_rdvalid | input | 1 | Read data valid |
| bus_waitreq | input | 1 | Slave stall |

## Verification
The bench builds the block with K_MIN = 0x000100 and K_MAX = 0x3F0000. These narrow limits let it probe the window at both edges, one step inside and one step outside, with values it can easily write by hand. The address strides keep their default values, so lane 3 and the fast PLL reach the highest register addresses. The bench slave can stall every access with waitrequest and always returns read data two cycles late, with junk on the data lines at other times. This exercises request holding and readdatavalid qualification under back-pressure.

// File: rtl/fpll_ktune_pkg.sv
package fpll_ktune_pkg;
  localparam int AW = 24;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    PLL_SLOW = 2'd0,
    PLL_MED  = 2'd1,
    PLL_FAST = 2'd2
  } pll_sel_e;

  // Register address from lane and PLL strides.
  function automatic logic [AW-1:0] pll_reg_addr(
    input logic [1:0]    lane,
    input logic [1:0]    pll,
    input logic [AW-1:0] base,
    input logic [AW-1:0] lane_stride,
    input logic [AW-1:0] pll_stride
  );
    return base + lane_stride * AW'(lane) + pll_stride * AW'(pll);
  endfunction

  // Replace the masked bits of a word that was read, keep the rest.
  function automatic logic [DW-1:0] field_merge(
    input logic [DW-1:0] old_word,
    input logic [DW-1:0] new_bits,
    input logic [DW-1:0] mask
  );
    return (old_word & ~mask) | (new_bits & mask);
  endfunction
endpackage

// File: rtl/fpll_req_check.sv
module fpll_req_check
  import fpll_ktune_pkg::*;
#(
  parameter int             K_W   = 22,
  parameter logic [K_W-1:0] K_MIN = 22'h000400,
  parameter logic [K_W-1:0] K_MAX = 22'h3FFC00
) (
  input  logic [1:0]     pll,
  input  logic [K_W-1:0] kval,
  output logic           bad_pll,
  output logic           bad_range
);
  assign bad_pll   = (pll > PLL_FAST);
  assign bad_range = (kval < K_MIN) || (kval > K_MAX);
endmodule

// File: rtl/fpll_addr_gen.sv
module fpll_addr_gen
  import fpll_ktune_pkg::*;
#(
  parameter logic [AW-1:0] BASE        = 24'h094000,
  parameter logic [AW-1:0] LANE_STRIDE = 24'h100000,
  parameter logic [AW-1:0] PLL_STRIDE  = 24'h000100,
  parameter logic [AW-1:0] STB_OFS     = 24'h00000C
) (
  input  logic [1:0]    lane,
  input  logic [1:0]    pll,
  output logic [AW-1:0] k_addr,
  output logic [AW-1:0] s_addr
);
  assign k_addr = pll_reg_addr(lane, pll, BASE, LANE_STRIDE, PLL_STRIDE);
  assign s_addr = k_addr + STB_OFS;
endmodule

// File: rtl/fpll_rmw_port.sv
module fpll_rmw_port
  import fpll_ktune_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] mask_in,
  input  logic [DW-1:0] val_in,
  output logic [AW-1:0] bus_addr,
  output logic          bus_read,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdvalid,
  input  logic          bus_waitreq,
  output logic          op_done
);
  typedef enum logic [1:0] {P_IDLE, P_RD, P_WAIT, P_WR} pst_e;

  pst_e          st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mask_q, val_q, wdata_q;
  logic          rd_accept, data_take, wr_accept;

  assign rd_accept = (st == P_RD)   && !bus_waitreq;
  assign data_take = (st == P_WAIT) && bus_rdvalid;
  assign wr_accept = (st == P_WR)   && !bus_waitreq;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= P_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      val_q   <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st)
        P_IDLE: if (start) begin
          addr_q <= addr_in;
          mask_q <= mask_in;
          val_q  <= val_in;
          st     <= P_RD;
        end
        P_RD:   if (rd_accept) st <= P_WAIT;
        P_WAIT: if (data_take) begin
          wdata_q <= field_merge(bus_rdata, val_q, mask_q);
          st      <= P_WR;
        end
        P_WR:   if (wr_accept) st <= P_IDLE;
        default: st <= P_IDLE;
      endcase
    end
  end

  assign bus_addr  = addr_q;
  assign bus_read  = (st == P_RD);
  assign bus_write = (st == P_WR);
  assign bus_wdata = wdata_q;
  assign op_done   = wr_accept;

  // R4: a stalled request keeps every request signal unchanged
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_read || bus_write) && bus_waitreq |=>
      $stable(bus_addr) && $stable(bus_wdata) &&
      (bus_read == $past(bus_read)) && (bus_write == $past(bus_write)));

  // R4: never read and write in the same cycle
  a_r4_one_cmd: assert property (@(posedge clk) disable iff (rst)
    !(bus_read && bus_write));

  // R2: bits outside the mask come from the read data
  a_r2_keep_bits: assert property (@(posedge clk) disable iff (rst)
    data_take |=> ((bus_wdata & ~mask_q) == ($past(bus_rdata) & ~mask_q)));
endmodule

// File: rtl/fpll_ktune_seq.sv
module fpll_ktune_seq
  import fpll_ktune_pkg::*;
#(
  parameter int             K_W         = 22,
  parameter int             K_LSB       = 9,
  parameter int             STB_BIT     = 17,
  parameter logic [K_W-1:0] K_MIN       = 22'h000400,
  parameter logic [K_W-1:0] K_MAX       = 22'h3FFC00,
  parameter logic [AW-1:0]  BASE        = 24'h094000,
  parameter logic [AW-1:0]  LANE_STRIDE = 24'h100000,
  parameter logic [AW-1:0]  PLL_STRIDE  = 24'h000100,
  parameter logic [AW-1:0]  STB_OFS     = 24'h00000C
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [1:0]     req_lane,
  input  logic [1:0]     req_pll,
  input  logic [K_W-1:0] req_kval,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_read,
  output logic           bus_write,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_rdvalid,
  input  logic           bus_waitreq
);
  localparam logic [DW-1:0] K_MASK   = {{(DW-K_W){1'b0}}, {K_W{1'b1}}} << K_LSB;
  localparam logic [DW-1:0] STB_MASK = DW'(1) << STB_BIT;
  localparam logic [1:0]    LAST_STEP = 2'd3;

  logic           busy_q, done_q, err_q, launch_q;
  logic [1:0]     step_q, lane_q, pll_q;
  logic [K_W-1:0] k_q;
  logic           bad_pll, bad_range, op_done;
  logic [AW-1:0]  k_addr, s_addr, op_addr;
  logic [DW-1:0]  op_mask, op_val;

  fpll_req_check #(.K_W(K_W), .K_MIN(K_MIN), .K_MAX(K_MAX)) u_check (
    .pll(req_pll), .kval(req_kval), .bad_pll(bad_pll), .bad_range(bad_range));

  fpll_addr_gen #(.BASE(BASE), .LANE_STRIDE(LANE_STRIDE),
                  .PLL_STRIDE(PLL_STRIDE), .STB_OFS(STB_OFS)) u_addr (
    .lane(lane_q), .pll(pll_q), .k_addr(k_addr), .s_addr(s_addr));

  // Step 0 writes the field; steps 1..3 drive the strobe 0, 1, 0.
  always_comb begin
    if (step_q == 2'd0) begin
      op_addr = k_addr;
      op_mask = K_MASK;
      op_val  = DW'(k_q) << K_LSB;
    end else begin
      op_addr = s_addr;
      op_mask = STB_MASK;
      op_val  = (step_q == 2'd2) ? STB_MASK : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      launch_q <= 1'b0;
      step_q   <= '0;
      lane_q   <= '0;
      pll_q    <= '0;
      k_q      <= '0;
    end else begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      launch_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          if (bad_pll || bad_range) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            busy_q   <= 1'b1;
            launch_q <= 1'b1;
            step_q   <= '0;
            lane_q   <= req_lane;
            pll_q    <= req_pll;
            k_q      <= req_kval;
          end
        end
      end else if (op_done) begin
        if (step_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q   <= step_q + 2'd1;
          launch_q <= 1'b1;
        end
      end
    end
  end

  fpll_rmw_port u_port (
    .clk(clk), .rst(rst), .start(launch_q),
    .addr_in(op_addr), .mask_in(op_mask), .val_in(op_val),
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdvalid(bus_rdvalid), .bus_waitreq(bus_waitreq),
    .op_done(op_done));

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  // R7: bus activity only inside an update
  a_r7_bus_in_busy: assert property (@(posedge clk) disable iff (rst)
    (bus_read || bus_write) |-> busy);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7/R8: busy falls only together with a clean done
  a_r8_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done && !err);

  // R5/R6: a rejection leaves the bus quiet
  a_r5_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> !busy && !bus_read && !bus_write);

  // R3: strobe writes carry 0, 1, 0 in steps 1, 2, 3
  a_r3_strobe_high: assert property (@(posedge clk) disable iff (rst)
    (bus_write && step_q == 2'd2) |-> bus_wdata[STB_BIT]);
  a_r3_strobe_low: assert property (@(posedge clk) disable iff (rst)
    (bus_write && (step_q == 2'd1 || step_q == 2'd3)) |-> !bus_wdata[STB_BIT]);

  // R9: reset leaves the block idle
  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> !busy && !done && !bus_read && !bus_write);
endmodule

// File: tb/fpll_ktune_seq_bench.sv
module fpll_ktune_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_lane = '0;
  logic [1:0]  req_pll = '0;
  logic [21:0] req_kval = '0;
  logic        busy, done, err, bus_read, bus_write;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = 32'hBAD0BAD0;
  logic        bus_rdvalid = 1'b0;
  logic        bus_waitreq;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  fpll_ktune_seq #(.K_MIN(22'h000100), .K_MAX(22'h3F0000)) u_fpll_ktune_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_lane(req_lane),
    .req_pll(req_pll), .req_kval(req_kval), .busy(busy), .done(done),
    .err(err), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdvalid(bus_rdvalid), .bus_waitreq(bus_waitreq));

  // ---------------- slave model ----------------
  bit [31:0]   mem [int unsigned];
  logic        stall_en = 1'b0;
  logic [1:0]  phase = '0;
  int          rd_cnt = 0;
  logic [31:0] rd_buf = '0;
  int          wr_n = 0, rd_n = 0;
  logic [31:0] wr_addr_log [16];
  logic [31:0] wr_data_log [16];
  int          total = 0, fails = 0;

  assign bus_waitreq = stall_en && (phase != 2'd3);

  function automatic bit [31:0] seed_val(input int unsigned a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A5A5A;
  endfunction

  function automatic bit [31:0] mem_get(input int unsigned a);
    if (mem.exists(a)) return mem[a];
    return seed_val(a);
  endfunction

  always @(posedge clk) begin
    phase <= phase + 2'd1;
    bus_rdvalid <= 1'b0;
    bus_rdata   <= 32'hBAD0BAD0;
    if (rd_cnt == 1) begin
      bus_rdvalid <= 1'b1;
      bus_rdata   <= rd_buf;
    end
    if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
    if (bus_read && !bus_waitreq) begin
      rd_buf <= mem_get(32'(bus_addr));
      rd_cnt <= 2;
      rd_n   = rd_n + 1;
    end
    if (bus_write && !bus_waitreq) begin
      mem[32'(bus_addr)] = bus_wdata;
      if (wr_n < 16) begin
        wr_addr_log[wr_n] = 32'(bus_addr);
        wr_data_log[wr_n] = bus_wdata;
      end
      wr_n = wr_n + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] k_reg(input int lane, input int pll);
    return 32'h094000 + 32'(lane) * 32'h100000 + 32'(pll) * 32'h100;
  endfunction

  task automatic clear_logs();
    wr_n = 0;
    rd_n = 0;
  endtask

  // Drive one request for one cycle; returns busy seen one cycle later.
  task automatic send(input int lane, input int pll, input logic [21:0] k,
                      output logic busy_after);
    @(negedge clk);
    req_valid = 1'b1;
    req_lane  = 2'(lane);
    req_pll   = 2'(pll);
    req_kval  = k;
    @(negedge clk);
    req_valid  = 1'b0;
    busy_after = busy;
  endtask

  task automatic wait_done(output logic got, output logic got_err);
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    got     = done;
    got_err = err;
  endtask

  // Compare the logged traffic against the expected R1/R2/R3 results.
  task automatic verify(input logic [31:0] ka, input logic [31:0] kold,
                        input logic [31:0] sold, input logic [21:0] k,
                        input string tag);
    logic [31:0] sa;
    sa = ka + 32'h0C;
    check(rd_n == 4, "R3", {tag, " read count"}, 32'(rd_n), 32'd4);
    check(wr_n == 4, "R3", {tag, " write count"}, 32'(wr_n), 32'd4);
    if (wr_n == 4) begin
      check(wr_addr_log[0] == ka, "R1", {tag, " tuning addr"}, wr_addr_log[0], ka);
      check(wr_data_log[0] == {kold[31], k, kold[8:0]}, "R2", {tag, " field merge"},
            wr_data_log[0], {kold[31], k, kold[8:0]});
      for (int i = 1; i < 4; i++) begin
        logic [31:0] exp;
        exp = {sold[31:18], (i == 2), sold[16:0]};
        check(wr_addr_log[i] == sa, "R1", {tag, " strobe addr"}, wr_addr_log[i], sa);
        check(wr_data_log[i] == exp, "R3", {tag, " strobe word"}, wr_data_log[i], exp);
      end
    end
  endtask

  task automatic run_ok(input int lane, input int pll, input logic [21:0] k,
                        input logic stall, input string tag);
    logic [31:0] ka, kold, sold;
    logic b, got, gerr;
    ka   = k_reg(lane, pll);
    kold = mem_get(ka);
    sold = mem_get(ka + 32'h0C);
    stall_en = stall;
    clear_logs();
    send(lane, pll, k, b);
    check(b == 1'b1, "R7", {tag, " busy after accept"}, 32'(b), 32'd1);
    wait_done(got, gerr);
    check(got == 1'b1, "R8", {tag, " done seen"}, 32'(got), 32'd1);
    check(gerr == 1'b0, "R8", {tag, " err low"}, 32'(gerr), 32'd0);
    check(busy == 1'b0, "R8", {tag, " busy low at done"}, 32'(busy), 32'd0);
    @(negedge clk);
    check(done == 1'b0, "R8", {tag, " done one cycle"}, 32'(done), 32'd0);
    verify(ka, kold, sold, k, tag);
    stall_en = 1'b0;
  endtask

  task automatic run_bad(input int lane, input int pll, input logic [21:0] k,
                         input string req, input string tag);
    logic b;
    clear_logs();
    send(lane, pll, k, b);
    check(done && err, req, {tag, " reject pulse"}, {30'd0, done, err}, 32'd3);
    check(b == 1'b0, req, {tag, " not busy"}, 32'(b), 32'd0);
    repeat (10) @(negedge clk);
    check(rd_n == 0 && wr_n == 0, req, {tag, " no bus access"},
          32'(rd_n + wr_n), 32'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    check(!busy && !done && !bus_read && !bus_write, "R9", "reset idle",
          {28'd0, busy, done, bus_read, bus_write}, 32'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] ka, kold, sold;
    logic b, got, gerr;
    ka   = k_reg(1, 1);
    kold = mem_get(ka);
    sold = mem_get(ka + 32'h0C);
    stall_en = 1'b1;
    clear_logs();
    send(1, 1, 22'h0ABCDE, b);
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_lane = 2'd2; req_pll = 2'd0; req_kval = 22'h111111;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done(got, gerr);
    check(got && !gerr, "R7", "first request completes", 32'(got), 32'd1);
    repeat (20) @(negedge clk);
    verify(ka, kold, sold, 22'h0ABCDE, "R7 ignored while busy");
    stall_en = 1'b0;
  endtask

  task automatic t_reset_mid();
    int r0, w0;
    logic b;
    stall_en = 1'b1;
    clear_logs();
    send(3, 2, 22'h200000, b);
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !bus_read && !bus_write, "R9", "mid-update reset idle",
          {29'd0, busy, bus_read, bus_write}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    r0 = rd_n; w0 = wr_n;
    repeat (30) @(negedge clk);
    check(rd_n == r0 && wr_n == w0 && !busy, "R9", "quiet after reset",
          32'(rd_n + wr_n - r0 - w0), 32'd0);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    run_ok(0, 0, 22'h012345, 1'b0, "R1 lane0 slow");
    run_ok(3, 2, 22'h3F0000, 1'b1, "R5 max lane3 fast stalled");
    run_ok(2, 1, 22'h000100, 1'b1, "R5 min lane2 medium");
    run_ok(0, 0, 22'h2AAAAA, 1'b1, "R4 repeat addr stalled");
    run_bad(0, 0, 22'h0000FF, "R5", "below min");
    run_bad(1, 2, 22'h3F0001, "R5", "above max");
    run_bad(2, 3, 22'h012345, "R6", "pll code 3");
    t_busy_ignore();
    t_reset_mid();
    run_ok(3, 2, 22'h155555, 1'b0, "R9 recovery");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule